// File: doc/BRIEF.md
# Downlink Command Frame Transmitter

This block turns control commands for a shared downlink into a stream of byte symbols. The link is multidropped to up to eight front-end chips. Each command carries a 4-bit chip address, a 4-bit sequence number, a 2-bit request type and a 14-bit payload. The request type selects one of three operations: read a register, set the write address, or write data. The block packs these fields into three header bytes and appends a 16-bit CRC. It sends the frame as six symbols: a K28.5 comma with the control flag set, then five data bytes. The symbols go to a downstream 8b/10b encoder.

The same output path also carries raw 10-bit words for link training. An external controller hands over a 20-bit special pattern through a request port. The block sends it as two raw words, and only between whole frames, so frame alignment is never broken. When nothing is waiting, the block fills each symbol slot with a K28.5 idle comma. A symbol-enable input paces the output at the encoder's rate. Each enabled cycle consumes exactly one symbol slot.

Top module: `dlf_downlink_tx`

## Requirements
- R1: While reset is asserted, the output is the idle comma: sym_word = 0x0BC, sym_k = 1, sym_raw = 0. Both cmd_ready and sync_ready are 1.
- R2: In an enabled slot with no command or pattern held, the block emits K28.5 (sym_word = 0x0BC) with sym_k = 1 and sym_raw = 0.
- R3: A held command is sent in six consecutive enabled slots: the K28.5 comma with sym_k = 1, then five data bytes in sym_word[7:0] with sym_k = 0 and sym_raw = 0. A second command accepted while the first is being sent starts in the slot right after the first one's last byte.
- R4: Data byte 1 is {address[3:0], sequence[3:0]}. Data byte 2 is {type[1:0], payload[13:8]}. Data byte 3 is payload[7:0]. All address values 0..15 pass through unchanged.
- R5: Data bytes 4 and 5 are the high and low bytes of a CRC-16 over data bytes 1..3. The CRC processes the data MSB first, uses polynomial 0x1021 and initial value 0xFFFF, and applies no final inversion.
- R6: A sync pattern is sent as two consecutive enabled slots with sym_raw = 1 and sym_k = 0. The first slot carries pattern bits 19:10 and the second carries bits 9:0, both in sym_word[9:0].
- R7: A pattern requested while a frame is in progress starts in the slot right after that frame's fifth data byte, never inside it.
- R8: A command accepted while a pattern is in progress starts in the slot right after the pattern's second raw word.
- R9: When a command and a pattern are both held at a frame boundary, the pattern is sent first and the frame follows it directly.
- R10: While sym_en is low, sym_word, sym_k and sym_raw keep their values and no frame or pattern advances.
- R11: Each input port has a one-entry holding register. Data transfers on a cycle with valid and ready both high. Ready stays low while the entry is held, until the sequencer takes it, even when sym_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command holding register free |
| cmd_addr | input | 4 | Target chip address |
| cmd_seq | input | 4 | Sequence number |
| cmd_type | input | 2 | Request type |
| cmd_payload | input | 14 | Command payload |
| sync_valid | input | 1 | Sync pattern offered |
| sync_ready | output | 1 | Pattern holding register free |
| sync_pattern | input | 20 | Raw 20-bit training pattern |
| sym_en | input | 1 | Symbol slot enable from the encoder |
| sym_word | output | 10 | Byte in bits 7:0, or raw 10-bit word |
| sym_k | output | 1 | Control-symbol flag |
| sym_raw | output | 1 | Raw word, bypass the encoder |

## Verification
The bench builds the block with its default field widths: 4-bit address and sequence, 2-bit type, 14-bit payload and 10-bit raw words. With these widths the header fills exactly three bytes and the whole frame is six slots. Under those values it can reach the frame boundary both with sym_en held high and with random gaps. This exposes collisions between patterns and commands on the slot just before, at, and just after a boundary. It also exercises address 15 and all-ones or all-zero payloads at the byte edges.

// File: rtl/dlf_pkg.sv
package dlf_pkg;
  localparam int          SYM_W = 8;
  localparam int          CRC_W = 16;
  localparam logic [7:0]  K28_5 = 8'hBC;

  typedef enum logic [1:0] {
    SEQ_BOUND    = 2'd0,
    SEQ_FRAME    = 2'd1,
    SEQ_RAW_TAIL = 2'd2
  } seq_state_e;
endpackage

// File: rtl/dlf_crc16.sv
module dlf_crc16 #(
  parameter int                     DATA_W = 24,
  parameter int                     CRC_W  = 16,
  parameter logic [CRC_W-1:0]       POLY   = 16'h1021,
  parameter logic [CRC_W-1:0]       INIT   = 16'hFFFF
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);
  // Bit-serial update unrolled over the whole header, MSB first.
  always_comb begin
    logic [CRC_W-1:0] c;
    c = INIT;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      if (c[CRC_W-1] ^ data_i[i]) c = {c[CRC_W-2:0], 1'b0} ^ POLY;
      else                         c = {c[CRC_W-2:0], 1'b0};
    end
    crc_o = c;
  end
endmodule

// File: rtl/dlf_hold.sv
module dlf_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  input  logic         take,
  output logic         ready,
  output logic         full,
  output logic [W-1:0] data
);
  logic         full_q, full_d;
  logic [W-1:0] data_q;
  logic         load;

  assign load  = in_valid && !full_q;
  assign ready = !full_q;
  assign full  = full_q;
  assign data  = data_q;

  always_comb begin
    full_d = full_q;
    if (take) full_d = 1'b0;
    if (load) full_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_d;
      if (load) data_q <= in_data;
    end
  end

  // R11: a held entry stays put until the sequencer takes it
  assert_hold_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !take) |=> (full_q && $stable(data_q)));
  // R11: nothing is taken from an empty entry
  assert_take_full_R11: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> full_q);
endmodule

// File: rtl/dlf_framer.sv
module dlf_framer #(
  parameter int                 ADDR_W   = 4,
  parameter int                 SEQ_W    = 4,
  parameter int                 TYPE_W   = 2,
  parameter int                 PAY_W    = 14,
  parameter logic [15:0]        CRC_POLY = 16'h1021,
  parameter logic [15:0]        CRC_INIT = 16'hFFFF,
  localparam int                HDR_W    = ADDR_W + SEQ_W + TYPE_W + PAY_W,
  localparam int                FRAME_W  = HDR_W + dlf_pkg::CRC_W
) (
  input  logic [HDR_W-1:0]   cmd_i,
  output logic [FRAME_W-1:0] frame_o
);
  logic [dlf_pkg::CRC_W-1:0] crc;

  // The header concatenation {addr, seq, type, payload} already lands on
  // the byte fields: addr|seq in byte 1, type|payload-high in byte 2.
  dlf_crc16 #(
    .DATA_W (HDR_W),
    .CRC_W  (dlf_pkg::CRC_W),
    .POLY   (CRC_POLY),
    .INIT   (CRC_INIT)
  ) u_crc (
    .data_i (cmd_i),
    .crc_o  (crc)
  );

  assign frame_o = {cmd_i, crc};
endmodule

// File: rtl/dlf_sequencer.sv
module dlf_sequencer
  import dlf_pkg::*;
#(
  parameter int  FRAME_W = 40,
  parameter int  RAW_W   = 10,
  localparam int DATA_BYTES = FRAME_W / SYM_W,
  localparam int IDX_W      = $clog2(DATA_BYTES),
  localparam int PAT_W      = 2 * RAW_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sym_en,
  input  logic               cmd_full,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               sync_full,
  input  logic [PAT_W-1:0]   pat_i,
  output logic               cmd_take,
  output logic               sync_take,
  output logic [RAW_W-1:0]   sym_word,
  output logic               sym_k,
  output logic               sym_raw
);
  localparam logic [RAW_W-1:0] IDLE_WORD = {{(RAW_W-SYM_W){1'b0}}, K28_5};
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(DATA_BYTES - 1);

  seq_state_e         st_q, st_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [RAW_W-1:0]   lo_q, lo_d;
  logic [RAW_W-1:0]   word_q, word_d;
  logic               k_q, k_d;
  logic               raw_q, raw_d;

  assign sym_word = word_q;
  assign sym_k    = k_q;
  assign sym_raw  = raw_q;

  always_comb begin
    st_d      = st_q;
    idx_d     = idx_q;
    sh_d      = sh_q;
    lo_d      = lo_q;
    word_d    = word_q;
    k_d       = k_q;
    raw_d     = raw_q;
    cmd_take  = 1'b0;
    sync_take = 1'b0;
    if (sym_en) begin
      unique case (st_q)
        SEQ_BOUND: begin
          if (sync_full) begin
            // training pattern wins at a boundary
            word_d    = pat_i[PAT_W-1:RAW_W];
            lo_d      = pat_i[RAW_W-1:0];
            k_d       = 1'b0;
            raw_d     = 1'b1;
            sync_take = 1'b1;
            st_d      = SEQ_RAW_TAIL;
          end else if (cmd_full) begin
            word_d   = IDLE_WORD;
            k_d      = 1'b1;
            raw_d    = 1'b0;
            sh_d     = frame_i;
            idx_d    = '0;
            cmd_take = 1'b1;
            st_d     = SEQ_FRAME;
          end else begin
            word_d = IDLE_WORD;
            k_d    = 1'b1;
            raw_d  = 1'b0;
          end
        end
        SEQ_FRAME: begin
          word_d = {{(RAW_W-SYM_W){1'b0}}, sh_q[FRAME_W-1 -: SYM_W]};
          k_d    = 1'b0;
          raw_d  = 1'b0;
          sh_d   = {sh_q[FRAME_W-SYM_W-1:0], {SYM_W{1'b0}}};
          if (idx_q == LAST_IDX) begin
            idx_d = '0;
            st_d  = SEQ_BOUND;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
        SEQ_RAW_TAIL: begin
          word_d = lo_q;
          k_d    = 1'b0;
          raw_d  = 1'b1;
          st_d   = SEQ_BOUND;
        end
        default: st_d = SEQ_BOUND;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_BOUND;
      idx_q  <= '0;
      sh_q   <= '0;
      lo_q   <= '0;
      word_q <= IDLE_WORD;
      k_q    <= 1'b1;
      raw_q  <= 1'b0;
    end else if (sym_en) begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      lo_q   <= lo_d;
      word_q <= word_d;
      k_q    <= k_d;
      raw_q  <= raw_d;
    end
  end

  // R2: a control symbol is always the plain comma, never raw
  assert_comma_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sym_k |-> (sym_word == IDLE_WORD && !sym_raw));
  // R7: no raw word can appear in a slot that belongs to a frame body
  assert_frame_unbroken_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_en && st_q == SEQ_FRAME) |=> (!sym_raw && !sym_k));
  // R6: the first raw word is always followed by its tail state
  assert_raw_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sym_raw)) |-> (st_q == SEQ_RAW_TAIL));
  // R10: a disabled slot freezes the output and the schedule
  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_en |=> ($stable(sym_word) && $stable(sym_k) && $stable(sym_raw) && $stable(st_q)));
  // R9: a held pattern blocks a command at the boundary
  assert_pattern_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_en && st_q == SEQ_BOUND && sync_full) |-> !cmd_take);
endmodule

// File: rtl/dlf_downlink_tx.sv
module dlf_downlink_tx #(
  parameter int          ADDR_W   = 4,
  parameter int          SEQ_W    = 4,
  parameter int          TYPE_W   = 2,
  parameter int          PAY_W    = 14,
  parameter int          RAW_W    = 10,
  parameter logic [15:0] CRC_POLY = 16'h1021,
  parameter logic [15:0] CRC_INIT = 16'hFFFF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [ADDR_W-1:0]   cmd_addr,
  input  logic [SEQ_W-1:0]    cmd_seq,
  input  logic [TYPE_W-1:0]   cmd_type,
  input  logic [PAY_W-1:0]    cmd_payload,
  input  logic                sync_valid,
  output logic                sync_ready,
  input  logic [2*RAW_W-1:0]  sync_pattern,
  input  logic                sym_en,
  output logic [RAW_W-1:0]    sym_word,
  output logic                sym_k,
  output logic                sym_raw
);
  localparam int HDR_W   = ADDR_W + SEQ_W + TYPE_W + PAY_W;
  localparam int FRAME_W = HDR_W + dlf_pkg::CRC_W;
  localparam int PAT_W   = 2 * RAW_W;

  logic [1:0]         rst_sync_q;
  logic               rst_n_s;
  logic               cmd_full, cmd_take;
  logic [HDR_W-1:0]   cmd_data;
  logic               sync_full, sync_take;
  logic [PAT_W-1:0]   sync_data;
  logic [FRAME_W-1:0] frame;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  dlf_hold #(.W(HDR_W)) u_cmd_hold (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .in_valid (cmd_valid),
    .in_data  ({cmd_addr, cmd_seq, cmd_type, cmd_payload}),
    .take     (cmd_take),
    .ready    (cmd_ready),
    .full     (cmd_full),
    .data     (cmd_data)
  );

  dlf_hold #(.W(PAT_W)) u_sync_hold (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .in_valid (sync_valid),
    .in_data  (sync_pattern),
    .take     (sync_take),
    .ready    (sync_ready),
    .full     (sync_full),
    .data     (sync_data)
  );

  dlf_framer #(
    .ADDR_W   (ADDR_W),
    .SEQ_W    (SEQ_W),
    .TYPE_W   (TYPE_W),
    .PAY_W    (PAY_W),
    .CRC_POLY (CRC_POLY),
    .CRC_INIT (CRC_INIT)
  ) u_framer (
    .cmd_i   (cmd_data),
    .frame_o (frame)
  );

  dlf_sequencer #(
    .FRAME_W (FRAME_W),
    .RAW_W   (RAW_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .sym_en    (sym_en),
    .cmd_full  (cmd_full),
    .frame_i   (frame),
    .sync_full (sync_full),
    .pat_i     (sync_data),
    .cmd_take  (cmd_take),
    .sync_take (sync_take),
    .sym_word  (sym_word),
    .sym_k     (sym_k),
    .sym_raw   (sym_raw)
  );
endmodule

// File: tb/dlf_downlink_tx_test.sv
module dlf_downlink_tx_test;
  logic        clk;
  logic        rst_n;
  logic        cmd_valid, cmd_ready;
  logic [3:0]  cmd_addr, cmd_seq;
  logic [1:0]  cmd_type;
  logic [13:0] cmd_payload;
  logic        sync_valid, sync_ready;
  logic [19:0] sync_pattern;
  logic        sym_en;
  logic [9:0]  sym_word;
  logic        sym_k, sym_raw;

  int checks = 0;
  int errors = 0;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  dlf_downlink_tx uut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_seq(cmd_seq), .cmd_type(cmd_type),
    .cmd_payload(cmd_payload),
    .sync_valid(sync_valid), .sync_ready(sync_ready), .sync_pattern(sync_pattern),
    .sym_en(sym_en), .sym_word(sym_word), .sym_k(sym_k), .sym_raw(sym_raw)
  );

  // symbol enable: directed or random
  logic rnd_mode, en_force;
  always @(negedge clk) sym_en <= rnd_mode ? (($urandom % 10) < 7) : en_force;

  // log of the symbol emitted in every enabled slot
  logic [9:0] lw [0:4095];
  logic       lk [0:4095];
  logic       lr [0:4095];
  int         ln;
  logic       en_seen;
  always @(posedge clk) en_seen <= sym_en;
  always @(negedge clk) begin
    if (rst_n && en_seen && ln < 4096) begin
      lw[ln] = sym_word; lk[ln] = sym_k; lr[ln] = sym_raw;
      ln = ln + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [23:0] d);
    logic [15:0] c = 16'hFFFF;
    for (int i = 23; i >= 0; i--) begin
      logic fb = c[15] ^ d[i];
      c = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  function automatic logic [7:0] ref_byte(input int n, input logic [3:0] a,
      input logic [3:0] s, input logic [1:0] t, input logic [13:0] p);
    logic [23:0] h = {a, s, t, p};
    logic [15:0] c = ref_crc(h);
    case (n)
      1: return h[23:16];
      2: return h[15:8];
      3: return h[7:0];
      4: return c[15:8];
      default: return c[7:0];
    endcase
  endfunction

  function automatic int find_frame(input int from);
    for (int i = from; i < ln; i++) if (!lk[i] && !lr[i]) return i - 1;
    return -1;
  endfunction

  function automatic int find_raw(input int from);
    for (int i = from; i < ln; i++) if (lr[i]) return i;
    return -1;
  endfunction

  task automatic check_frame(input int st, input logic [3:0] a, input logic [3:0] s,
      input logic [1:0] t, input logic [13:0] p, input string req);
    chk(st >= 0 && st + 5 < ln, req, "frame present", st, 0);
    if (st >= 0 && st + 5 < ln) begin
      chk(lw[st] == 10'h0BC && lk[st] && !lr[st], req, "frame comma", lw[st], 10'h0BC);
      for (int n = 1; n <= 5; n++) begin
        logic [9:0] e = {2'b00, ref_byte(n, a, s, t, p)};
        chk(lw[st+n] == e && !lk[st+n] && !lr[st+n], req, $sformatf("byte %0d", n),
            lw[st+n], e);
      end
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_cmd(input logic [3:0] a, input logic [3:0] s,
                          input logic [1:0] t, input logic [13:0] p);
    bit r;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_addr = a; cmd_seq = s; cmd_type = t; cmd_payload = p;
    do begin r = cmd_ready; @(negedge clk); end while (!r);
    cmd_valid = 1'b0;
  endtask

  task automatic send_sync(input logic [19:0] pat);
    bit r;
    @(negedge clk);
    sync_valid = 1'b1; sync_pattern = pat;
    do begin r = sync_ready; @(negedge clk); end while (!r);
    sync_valid = 1'b0;
  endtask

  task automatic send_both(input logic [19:0] pat, input logic [3:0] a,
      input logic [3:0] s, input logic [1:0] t, input logic [13:0] p);
    @(negedge clk);
    sync_valid = 1'b1; sync_pattern = pat;
    cmd_valid = 1'b1; cmd_addr = a; cmd_seq = s; cmd_type = t; cmd_payload = p;
    @(negedge clk);
    sync_valid = 1'b0; cmd_valid = 1'b0;
  endtask

  task automatic check_raw(input int r, input logic [19:0] pat, input string req);
    chk(r >= 0 && r + 1 < ln, req, "pattern present", r, 0);
    if (r >= 0 && r + 1 < ln) begin
      chk(lw[r] == pat[19:10] && lr[r] && !lk[r], req, "raw high word", lw[r], pat[19:10]);
      chk(lw[r+1] == pat[9:0] && lr[r+1] && !lk[r+1], req, "raw low word", lw[r+1], pat[9:0]);
    end
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    int st, r, dummy;
    logic [9:0] hold_w; logic hold_k, hold_r;
    dummy = $urandom(32'h5EED1);
    ln = 0; rnd_mode = 1'b0; en_force = 1'b1;
    rst_n = 1'b0; cmd_valid = 1'b0; sync_valid = 1'b0;
    cmd_addr = '0; cmd_seq = '0; cmd_type = '0; cmd_payload = '0; sync_pattern = '0;
    idle(3);
    // R1
    chk(sym_word == 10'h0BC && sym_k && !sym_raw, "R1", "reset output", sym_word, 10'h0BC);
    chk(cmd_ready && sync_ready, "R1", "reset ready", {cmd_ready, sync_ready}, 2'b11);
    rst_n = 1'b1;
    idle(4);

    // R2 idle commas
    ln = 0; idle(6);
    chk(ln >= 5, "R2", "idle slots", ln, 5);
    for (int i = 0; i < ln; i++)
      chk(lw[i] == 10'h0BC && lk[i] && !lr[i], "R2", "idle comma", lw[i], 10'h0BC);

    // R3 R4 R5 single frame
    ln = 0; send_cmd(4'd5, 4'hA, 2'd2, 14'h1ABC); idle(10);
    check_frame(find_frame(0), 4'd5, 4'hA, 2'd2, 14'h1ABC, "R5");

    // R4 extremes, R3 back-to-back
    ln = 0;
    send_cmd(4'd15, 4'hF, 2'd3, 14'h3FFF);
    send_cmd(4'd0, 4'h0, 2'd0, 14'h0000);
    idle(16);
    st = find_frame(0);
    check_frame(st, 4'd15, 4'hF, 2'd3, 14'h3FFF, "R4");
    check_frame(st + 6, 4'd0, 4'h0, 2'd0, 14'h0000, "R3");

    // R6 pattern alone
    ln = 0; send_sync(20'h003FF); idle(6);
    r = find_raw(0);
    check_raw(r, 20'h003FF, "R6");
    if (r >= 0) chk(lk[r+2] && lw[r+2] == 10'h0BC, "R6", "idle after pattern", lw[r+2], 10'h0BC);

    // R7 pattern during a frame
    ln = 0; send_cmd(4'd3, 4'h1, 2'd1, 14'h0155); idle(2); send_sync(20'hCFC0C); idle(12);
    st = find_frame(0);
    check_frame(st, 4'd3, 4'h1, 2'd1, 14'h0155, "R7");
    r = find_raw(0);
    chk(r == st + 6, "R7", "pattern after last byte", r, st + 6);
    check_raw(r, 20'hCFC0C, "R7");

    // R8 command during a pattern
    ln = 0; send_sync(20'hABCDE); send_cmd(4'd7, 4'h2, 2'd0, 14'h2A5A); idle(12);
    r = find_raw(0); st = find_frame(0);
    check_raw(r, 20'hABCDE, "R8");
    chk(st == r + 2, "R8", "frame after pattern", st, r + 2);
    check_frame(st, 4'd7, 4'h2, 2'd0, 14'h2A5A, "R8");

    // R9 both held together
    ln = 0; send_both(20'h12345, 4'd6, 4'h9, 2'd3, 14'h0F0F); idle(12);
    r = find_raw(0); st = find_frame(0);
    check_raw(r, 20'h12345, "R9");
    chk(st == r + 2, "R9", "pattern before frame", st, r + 2);
    check_frame(st, 4'd6, 4'h9, 2'd3, 14'h0F0F, "R9");

    // R10 stall mid-frame
    ln = 0; send_cmd(4'd1, 4'h4, 2'd2, 14'h1234); idle(1);
    en_force = 1'b0; idle(2);
    hold_w = sym_word; hold_k = sym_k; hold_r = sym_raw;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(sym_word == hold_w && sym_k == hold_k && sym_raw == hold_r, "R10",
          "stalled output", sym_word, hold_w);
    end
    en_force = 1'b1; idle(12);
    check_frame(find_frame(0), 4'd1, 4'h4, 2'd2, 14'h1234, "R10");

    // R11 ready while held
    en_force = 1'b0; idle(2); ln = 0;
    send_cmd(4'd2, 4'h8, 2'd1, 14'h3001);
    chk(!cmd_ready, "R11", "cmd_ready low while held", cmd_ready, 0);
    send_sync(20'hFFFFF);
    chk(!sync_ready, "R11", "sync_ready low while held", sync_ready, 0);
    idle(3);
    chk(!cmd_ready && !sync_ready, "R11", "ready low without slots", {cmd_ready, sync_ready}, 0);
    chk(ln == 0, "R11", "no slot while disabled", ln, 0);
    en_force = 1'b1; idle(12);
    chk(cmd_ready && sync_ready, "R11", "ready after taken", {cmd_ready, sync_ready}, 2'b11);
    r = find_raw(0); st = find_frame(0);
    check_raw(r, 20'hFFFFF, "R11");
    check_frame(st, 4'd2, 4'h8, 2'd1, 14'h3001, "R11");

    // random phase with gapped slots
    rnd_mode = 1'b1;
    for (int it = 0; it < 40; it++) begin
      logic [3:0] a; logic [3:0] s; logic [1:0] t; logic [13:0] p; logic [19:0] pt;
      bit with_sync;
      a = ($urandom % 9 == 8) ? 4'd15 : 4'($urandom % 8);
      s = 4'($urandom); t = 2'($urandom); p = 14'($urandom); pt = 20'($urandom);
      with_sync = ($urandom % 3) == 0;
      idle(4); ln = 0;
      if (with_sync) send_sync(pt);
      send_cmd(a, s, t, p);
      for (int w = 0; w < 200 && ln < 14; w++) @(negedge clk);
      st = find_frame(0);
      check_frame(st, a, s, t, p, "R3");
      if (with_sync) begin
        r = find_raw(0);
        check_raw(r, pt, "R6");
        chk(st == r + 2, "R8", "random frame after pattern", st, r + 2);
      end
    end
    rnd_mode = 1'b0;
    idle(4);
    summary();
    $finish;
  end
endmodule